// File: doc/BRIEF.md
# Program/Erase Sequencer with Status Byte

This block carries out the long-running write operations of a non-volatile word memory after the command decoder has launched them. There are four operation kinds: single-word program, two-word program, block erase and one-time security-register program. Each kind is modelled as a count of pulse cycles set by a parameter. A fail-injection input stands in for the verify result. The block keeps an 8-bit status byte that software polls. The byte holds a ready flag, two suspend flags and four sticky error flags.

The decoder raises one start strobe for one cycle, with the supply-OK sample and the target-protected flag valid in the same cycle. A request to suspend freezes the pulse count. After a latency that depends on the kind, the controller parks and reports ready. A resume continues from the preserved count. While an erase is parked, a word or two-word program may be started. It nests on top of the parked erase, and a resume always continues the most recently parked operation. An active-low abort input cancels everything within one cycle.

Top module: `pgm_erase_ctrl`

## Requirements
- R1: After reset the status byte is 0x80 and busy and suspended are 0. Bit 0 of the status byte always reads 0.
- R2: An accepted start keeps busy at 1, and status bit 7 at 0, for exactly the configured cycle count of its kind. The defaults are 12 for word, 16 for two-word, 40 for erase and 10 for security-register program.
- R3: op_fail is sampled only in the final pulse cycle. If it is 1 there, status bit 4 is set for a program kind and status bit 5 is set for erase.
- R4: If vpp_ok is 0 in the start cycle, status bit 3 is set and the operation does not run. A change of vpp_ok after the start has no effect.
- R5: If tgt_protected is 1 in the start cycle, status bit 1 is set and the operation does not run. For a security-register program, status bit 4 is also set.
- R6: Bits 1, 3, 4 and 5 stay set across later operations until clr_status clears them. If a set event and clr_status fall in the same cycle, the set wins.
- R7: A suspend of a running program keeps busy high for PGM_SUSP_CYCLES (default 2). The controller then parks with status bit 2 set, bit 7 set and suspended set. The total busy time of the suspended and resumed program is its cycle count plus the latency.
- R8: A suspend of a running erase takes ERS_SUSP_CYCLES (default 6) and parks with status bit 6 set. A resume clears the suspend bit and finishes the remaining pulses.
- R9: While an erase is parked, a word or two-word start nests. Status bits 2 and 6 are never both 1: a parked nested program shows bit 2 only. A resume continues the most recently parked operation.
- R10: A suspend request during a security-register program is ignored, and that program runs its full count.
- R11: abort_n low cancels running and parked operations by the next cycle. Busy and suspended go to 0 and the sticky error bits are kept.
- R12: A start is ignored while busy or while a program is parked. An erase start is ignored while an erase is parked.
- R13: A suspend request in the final pulse cycle is ignored, and the operation completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_n | input | 1 | Active-low operation abort |
| start_word | input | 1 | Start single-word program (strobe) |
| start_dword | input | 1 | Start two-word program (strobe) |
| start_erase | input | 1 | Start block erase (strobe) |
| start_preg | input | 1 | Start security-register program (strobe) |
| susp_req | input | 1 | Suspend request (strobe) |
| resume_req | input | 1 | Resume request (strobe) |
| clr_status | input | 1 | Clear sticky status bits 1, 3, 4, 5 |
| vpp_ok | input | 1 | Program supply above lockout, sampled at start |
| tgt_protected | input | 1 | Target block protected, sampled at start |
| op_fail | input | 1 | Verify failure, sampled in the final pulse |
| status | output | 8 | Status byte |
| busy | output | 1 | Operation running or suspending |
| suspended | output | 1 | An operation is parked |

## Verification
Two pairs of events can fall in the same cycle. In the first, clr_status arrives on the very edge where a failing operation completes. The bench drives it exactly N cycles after the start, with status bit 3 already set, and expects 0x90: the old flag is cleared and the fresh failure flag is kept. In the second, a suspend request lands in the final pulse cycle. The bench expects one busy run of the full count that ends ready with no suspend bit.

// File: rtl/pec_pkg.sv
package pec_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WORD  = 3'd1,
    OP_DWORD = 3'd2,
    OP_ERASE = 3'd3,
    OP_PREG  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    SL_IDLE = 2'd0,
    SL_RUN  = 2'd1,
    SL_HALT = 2'd2,
    SL_PARK = 2'd3
  } slot_e;

  localparam int SB_READY = 7;
  localparam int SB_ESUSP = 6;
  localparam int SB_EFAIL = 5;
  localparam int SB_PFAIL = 4;
  localparam int SB_VPP   = 3;
  localparam int SB_PSUSP = 2;
  localparam int SB_PROT  = 1;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pec_slot.sv
module pec_slot
  import pec_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             load,
  input  op_e              load_op,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             susp,
  input  logic [LAT_W-1:0] susp_lat,
  input  logic             resume,
  output slot_e            state,
  output op_e              op,
  output logic             fin
);

  logic [CNT_W-1:0] cnt_q;
  logic [LAT_W-1:0] lat_q;

  // final pulse: the operation retires on this edge
  assign fin = (state == SL_RUN) && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || kill) begin
      state <= SL_IDLE;
      op    <= OP_NONE;
      cnt_q <= '0;
      lat_q <= '0;
    end else begin
      case (state)
        SL_IDLE: begin
          if (load) begin
            state <= SL_RUN;
            op    <= load_op;
            cnt_q <= load_cnt;
          end
        end
        SL_RUN: begin
          if (fin) begin
            state <= SL_IDLE;
            op    <= OP_NONE;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (susp) begin
              state <= SL_HALT;
              lat_q <= susp_lat;
            end
          end
        end
        SL_HALT: begin
          if (lat_q <= LAT_W'(1)) state <= SL_PARK;
          else                     lat_q <= lat_q - LAT_W'(1);
        end
        default: begin
          if (resume) state <= SL_RUN;
        end
      endcase
    end
  end

endmodule

// File: rtl/pec_status.sv
module pec_status
  import pec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       set_prot,
  input  logic       set_vpp,
  input  logic       set_pfail,
  input  logic       set_efail,
  input  logic       busy,
  input  logic       psusp,
  input  logic       esusp,
  output logic [7:0] status
);

  logic [3:0] err_q;   // {efail, pfail, vpp, prot}
  logic [3:0] err_set;

  assign err_set = {set_efail, set_pfail, set_vpp, set_prot};

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (clr ? 4'b0 : err_q) | err_set;
  end

  always_comb begin
    status           = '0;
    status[SB_READY] = !busy;
    status[SB_ESUSP] = esusp;
    status[SB_EFAIL] = err_q[3];
    status[SB_PFAIL] = err_q[2];
    status[SB_VPP]   = err_q[1];
    status[SB_PSUSP] = psusp;
    status[SB_PROT]  = err_q[0];
  end

endmodule

// File: rtl/pgm_erase_ctrl.sv
module pgm_erase_ctrl
  import pec_pkg::*;
#(
  parameter int WORD_CYCLES     = 12,
  parameter int DWORD_CYCLES    = 16,
  parameter int ERASE_CYCLES    = 40,
  parameter int PREG_CYCLES     = 10,
  parameter int PGM_SUSP_CYCLES = 2,
  parameter int ERS_SUSP_CYCLES = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort_n,
  input  logic       start_word,
  input  logic       start_dword,
  input  logic       start_erase,
  input  logic       start_preg,
  input  logic       susp_req,
  input  logic       resume_req,
  input  logic       clr_status,
  input  logic       vpp_ok,
  input  logic       tgt_protected,
  input  logic       op_fail,
  output logic [7:0] status,
  output logic       busy,
  output logic       suspended
);

  localparam int MAX_CYC = imax(imax(WORD_CYCLES, DWORD_CYCLES),
                                imax(ERASE_CYCLES, PREG_CYCLES));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int MAX_LAT = imax(PGM_SUSP_CYCLES, ERS_SUSP_CYCLES);
  localparam int LAT_W   = $clog2(MAX_LAT + 1);
  localparam int NSLOT   = 2;   // 0: outer operation, 1: program nested in a parked erase

  slot_e            st   [NSLOT];
  op_e              sop  [NSLOT];
  logic             fin  [NSLOT];
  logic             ld   [NSLOT];
  logic             sus  [NSLOT];
  logic             res  [NSLOT];
  logic [NSLOT-1:0] fail_p, fail_e;

  op_e              req_op;
  logic [CNT_W-1:0] req_cnt;
  logic             start_any, req_is_pgm;
  logic             all_idle, nest_ok, take0, take1, take, bad;
  logic             tsel;
  slot_e            tgt_st;
  op_e              tgt_op;
  logic             tgt_fin, susp_ok, res_ok;
  logic [LAT_W-1:0] lat_sel;
  logic             psusp, esusp;

  // request decode
  always_comb begin
    req_op  = OP_NONE;
    req_cnt = '0;
    if (start_erase) begin
      req_op  = OP_ERASE;
      req_cnt = CNT_W'(ERASE_CYCLES);
    end else if (start_dword) begin
      req_op  = OP_DWORD;
      req_cnt = CNT_W'(DWORD_CYCLES);
    end else if (start_word) begin
      req_op  = OP_WORD;
      req_cnt = CNT_W'(WORD_CYCLES);
    end else if (start_preg) begin
      req_op  = OP_PREG;
      req_cnt = CNT_W'(PREG_CYCLES);
    end
  end

  assign start_any  = start_word | start_dword | start_erase | start_preg;
  assign req_is_pgm = (req_op == OP_WORD) || (req_op == OP_DWORD);
  assign all_idle   = (st[0] == SL_IDLE) && (st[1] == SL_IDLE);
  assign nest_ok    = (st[0] == SL_PARK) && (sop[0] == OP_ERASE) && (st[1] == SL_IDLE);
  assign take0      = abort_n && all_idle && start_any;
  assign take1      = abort_n && nest_ok && req_is_pgm && !resume_req;
  assign take       = take0 | take1;
  assign bad        = !vpp_ok || tgt_protected;

  // top of the suspend stack
  assign tsel    = (st[1] != SL_IDLE);
  assign tgt_st  = st[tsel];
  assign tgt_op  = sop[tsel];
  assign tgt_fin = fin[tsel];
  assign susp_ok = abort_n && susp_req && (tgt_st == SL_RUN) && !tgt_fin && (tgt_op != OP_PREG);
  assign res_ok  = abort_n && resume_req && (tgt_st == SL_PARK);
  assign lat_sel = (tgt_op == OP_ERASE) ? LAT_W'(ERS_SUSP_CYCLES) : LAT_W'(PGM_SUSP_CYCLES);

  assign ld[0] = take0 && !bad;
  assign ld[1] = take1 && !bad;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign sus[g]    = susp_ok && (tsel == 1'(g));
    assign res[g]    = res_ok  && (tsel == 1'(g));
    assign fail_p[g] = abort_n && fin[g] && op_fail && (sop[g] != OP_ERASE);
    assign fail_e[g] = abort_n && fin[g] && op_fail && (sop[g] == OP_ERASE);

    pec_slot #(.CNT_W(CNT_W), .LAT_W(LAT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .kill     (!abort_n),
      .load     (ld[g]),
      .load_op  (req_op),
      .load_cnt (req_cnt),
      .susp     (sus[g]),
      .susp_lat (lat_sel),
      .resume   (res[g]),
      .state    (st[g]),
      .op       (sop[g]),
      .fin      (fin[g])
    );
  end

  assign busy      = (st[0] == SL_RUN) || (st[0] == SL_HALT) ||
                     (st[1] == SL_RUN) || (st[1] == SL_HALT);
  assign psusp     = (tgt_st == SL_PARK) && (tgt_op != OP_ERASE);
  assign esusp     = (st[0] == SL_PARK) && (sop[0] == OP_ERASE) && !psusp;
  assign suspended = psusp | esusp;

  pec_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_status),
    .set_prot  (take && tgt_protected),
    .set_vpp   (take && !vpp_ok),
    .set_pfail ((|fail_p) || (take && tgt_protected && (req_op == OP_PREG))),
    .set_efail (|fail_e),
    .busy      (busy),
    .psusp     (psusp),
    .esusp     (esusp),
    .status    (status)
  );

endmodule

// File: rtl/pgm_erase_ctrl_chk.sv
module pgm_erase_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       abort_n,
  input logic       start_word,
  input logic       start_dword,
  input logic       start_erase,
  input logic       start_preg,
  input logic       clr_status,
  input logic       vpp_ok,
  input logic       tgt_protected,
  input logic [7:0] status,
  input logic       busy,
  input logic       suspended
);

  logic any_start;
  assign any_start = start_word | start_dword | start_erase | start_preg;

  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_n && !busy && !suspended && start_word && vpp_ok && !tgt_protected) |=> busy);

  assert_vpp_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_n && !busy && !suspended && any_start && !vpp_ok) |=> (status[3] && !busy));

  assert_prot_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_n && !busy && !suspended && any_start && tgt_protected) |=> (status[1] && !busy));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status && !busy && !any_start) |=> (status[5:3] == 3'b000 && !status[1]));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_status && status[4]) |=> status[4]);

  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_n |=> (!busy && !suspended));

  assert_park_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> status[7]);

endmodule

bind pgm_erase_ctrl pgm_erase_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .abort_n       (abort_n),
  .start_word    (start_word),
  .start_dword   (start_dword),
  .start_erase   (start_erase),
  .start_preg    (start_preg),
  .clr_status    (clr_status),
  .vpp_ok        (vpp_ok),
  .tgt_protected (tgt_protected),
  .status        (status),
  .busy          (busy),
  .suspended     (suspended)
);

// File: tb/pgm_erase_ctrl_bench.sv
module pgm_erase_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 12, ND = 16, NE = 40, NP = 10, LP = 2, LE = 6;

  logic clk = 0, rst_n = 0, abort_n = 1;
  logic start_word = 0, start_dword = 0, start_erase = 0, start_preg = 0;
  logic susp_req = 0, resume_req = 0, clr_status = 0;
  logic vpp_ok = 1, tgt_protected = 0, op_fail = 0;
  logic [7:0] status;
  logic busy, suspended;

  int n_chk = 0, n_bad = 0;
  int q_len[$];
  int q_st[$];
  string q_tag[$];
  int run_len = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgm_erase_ctrl u_pgm_erase_ctrl (
    .clk(clk), .rst_n(rst_n), .abort_n(abort_n),
    .start_word(start_word), .start_dword(start_dword),
    .start_erase(start_erase), .start_preg(start_preg),
    .susp_req(susp_req), .resume_req(resume_req), .clr_status(clr_status),
    .vpp_ok(vpp_ok), .tgt_protected(tgt_protected), .op_fail(op_fail),
    .status(status), .busy(busy), .suspended(suspended)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect_run(input string tag, input int len, input int st);
    q_len.push_back(len);
    q_st.push_back(st);
    q_tag.push_back(tag);
  endtask

  // monitor: each busy run is popped and compared when it ends
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) run_len++;
      else if (run_len > 0) begin
        if (q_len.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL unexpected run (R12) actual=len %0d expected=no run", run_len);
        end else begin
          chk({q_tag[0], " run length"}, run_len, q_len[0]);
          chk({q_tag[0], " status at end"}, int'(status), q_st[0]);
          void'(q_len.pop_front());
          void'(q_st.pop_front());
          void'(q_tag.pop_front());
        end
        run_len = 0;
      end
    end
  end

  // kind: 0 word, 1 dword, 2 erase, 3 security register
  task automatic go(input int kind);
    @(negedge clk);
    case (kind)
      0: start_word = 1;
      1: start_dword = 1;
      2: start_erase = 1;
      default: start_preg = 1;
    endcase
    @(negedge clk);
    start_word = 0; start_dword = 0; start_erase = 0; start_preg = 0;
  endtask

  task automatic pulse_susp();
    susp_req = 1; @(negedge clk); susp_req = 0;
  endtask

  task automatic pulse_resume();
    @(negedge clk); resume_req = 1; @(negedge clk); resume_req = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_status = 1; @(negedge clk); clr_status = 0;
  endtask

  task automatic drain();
    while (q_len.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset status", int'(status), 'h80);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset suspended", int'(suspended), 0);

    // R2 each kind runs its count
    expect_run("R2 word", NW, 'h80);  go(0); drain();
    expect_run("R2 dword", ND, 'h80); go(1); drain();
    expect_run("R2 erase", NE, 'h80); go(2); drain();
    expect_run("R2 preg", NP, 'h80);  go(3); drain();

    // R3 fail only sampled in the final pulse
    op_fail = 1;
    expect_run("R3 early fail ignored", NW, 'h80); go(0);
    repeat (NW - 3) @(negedge clk);
    op_fail = 0; drain();
    expect_run("R3 word fail", NW, 'h90); op_fail = 1; go(0); drain(); op_fail = 0;
    // R6 persists across a good operation
    expect_run("R6 sticky word fail", NW, 'h90); go(0); drain();
    pulse_clr(); chk("R6 clear", int'(status), 'h80);
    expect_run("R3 erase fail", NE, 'hA0); op_fail = 1; go(2); drain(); op_fail = 0;
    pulse_clr();

    // R4 supply low at start; supply drop after start ignored
    vpp_ok = 0; go(0);
    chk("R4 vpp flag", int'(status), 'h88);
    chk("R4 no run", int'(busy), 0);
    vpp_ok = 1;
    // R6 coincidence: clear on the failing completion edge
    op_fail = 1;
    expect_run("R6 clear vs fail same cycle", NW, 'h90);
    go(0);
    repeat (NW - 1) @(negedge clk);
    clr_status = 1; @(negedge clk); clr_status = 0; op_fail = 0;
    drain();
    pulse_clr();
    expect_run("R4 vpp drop after start", NW, 'h80);
    go(0); vpp_ok = 0; drain(); vpp_ok = 1;

    // R5 protected target
    tgt_protected = 1; go(0);
    chk("R5 protected word", int'(status), 'h82);
    pulse_clr();
    go(3);
    chk("R5 protected preg", int'(status), 'h92);
    tgt_protected = 0;
    pulse_clr();

    // R7 program suspend: j=4 -> 4+1+LP, then remainder
    expect_run("R7 word parks", 4 + 1 + LP, 'h84);
    go(0); repeat (4) @(negedge clk); pulse_susp(); drain();
    chk("R7 suspended flag", int'(suspended), 1);
    // R12 start ignored while program parked
    go(1); @(negedge clk);
    chk("R12 start while program parked", int'(busy), 0);
    expect_run("R7 word resumes", NW - 5, 'h80); pulse_resume(); drain();

    // R8 erase suspend, R9 nesting
    expect_run("R8 erase parks", 9 + 1 + LE, 'hC0);
    go(2); repeat (9) @(negedge clk); pulse_susp(); drain();
    go(2); @(negedge clk);
    chk("R12 erase start while erase parked", int'(status), 'hC0);
    expect_run("R9 nested word", NW, 'hC0); go(0); drain();
    expect_run("R9 nested word parks", 2 + 1 + LP, 'h84);
    go(0); repeat (2) @(negedge clk); pulse_susp(); drain();
    expect_run("R9 nested word resumes", NW - 3, 'hC0); pulse_resume(); drain();
    expect_run("R8 erase resumes", NE - 10, 'h80); pulse_resume(); drain();

    // R10 security register ignores suspend
    expect_run("R10 preg no suspend", NP, 'h80);
    go(3); repeat (2) @(negedge clk); pulse_susp(); drain();
    chk("R10 not suspended", int'(suspended), 0);

    // R13 suspend in final pulse ignored
    expect_run("R13 suspend at final pulse", NW, 'h80);
    go(0); repeat (NW - 1) @(negedge clk); pulse_susp(); drain();

    // R12 start ignored while busy
    expect_run("R12 start while busy", NW, 'h80);
    go(0); start_erase = 1; @(negedge clk); start_erase = 0; drain();
    repeat (3) @(negedge clk);
    chk("R12 idle after", int'(busy), 0);

    // R11 abort running, then abort parked erase keeping sticky bits
    expect_run("R11 abort running", 6, 'h80);
    go(2); repeat (5) @(negedge clk); abort_n = 0; @(negedge clk); abort_n = 1; drain();
    expect_run("R11 setup fail", NW, 'h90); op_fail = 1; go(0); drain(); op_fail = 0;
    expect_run("R11 erase parks", 3 + 1 + LE, 'hD0);
    go(2); repeat (3) @(negedge clk); pulse_susp(); drain();
    @(negedge clk); abort_n = 0; @(negedge clk); abort_n = 1;
    chk("R11 abort parked status", int'(status), 'h90);
    chk("R11 abort parked suspended", int'(suspended), 0);

    repeat (4) @(negedge clk);
    chk("R12 queue drained", q_len.size(), 0);
    finish_run();
  end
endmodule